// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block watches the command pins of a single-data-rate SDRAM bus without ever driving them. On each clock edge it decodes chip-select, RAS, CAS and WE into one command. It keeps a small state machine for every bank, whose states are idle, row open, read burst in progress and precharge in progress. It then judges the command against a rule table chosen by the state of the addressed bank. Commands that act on every bank are judged against all banks at once: precharge with the all-bank bit set, refresh, and mode register set.

For each sampled command it produces three things. The first is a registered command code. The second is a one-cycle flag when the command breaks a rule. The third is a packed vector of all bank states, so that a controller under test can be checked cycle by cycle. Precharge time, burst length and CAS latency are elaboration parameters. Internal timers move banks out of the precharge and read states on their own.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: One cycle after each edge, `cmd_code` holds the decoded command. It is 0 (deselect) whenever `cs_n` is high, regardless of the other pins. With `cs_n` low, {ras_n,cas_n,we_n} map as follows: 111 gives 1 (no-op), 110 gives 2 (burst stop), 101 gives 3 (read), 100 gives 4 (write), 011 gives 5 (activate), 010 gives 6 (precharge), 001 gives 7 (refresh) and 000 gives 8 (mode set). Deselect and no-op are never flagged.
- R2: A synchronous reset clears `cmd_code` and `illegal_cmd` to 0 and puts every bank in idle. Bank b occupies `bank_state[2b+1:2b]`, encoded as idle=0, row open=1, reading=2, precharging=3.
- R3: Activate is legal only when the addressed bank is idle, and it opens that bank. An activate to a bank that is open, reading or precharging is flagged.
- R4: Read and write are legal only when the addressed bank is open or reading. A read puts the bank in reading. A write leaves it open, and if it was reading, the read is cut off.
- R5: After a read, the bank shows reading for CAS_LAT+BURST_LEN-1 cycles and then returns to open on its own. A new read to a reading bank restarts that window.
- R6: Burst stop is legal only while some bank is reading, and it returns every reading bank to open.
- R7: Precharge is always legal. With `addr_ap` low it acts on the addressed bank. With `addr_ap` high it acts on all banks. Open or reading banks become precharging. Idle banks stay idle, and precharging banks keep their running timer.
- R8: A precharging bank becomes idle by itself. An activate to it is legal T_RP cycles after the precharge command and flagged one cycle earlier.
- R9: Refresh and mode register set are legal only when every bank is idle. Otherwise they are flagged.
- R10: A read or write to one bank ends a read burst in progress on any other bank, returning that bank to open.
- R11: A flagged command changes no bank state. `illegal_cmd` is high for exactly the cycle in which `cmd_code` reports that command.
- R12: While `cke` is low, the command is still reported, but it is not checked, never flagged and has no effect on bank states. The bank timers keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable; checking happens only while high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_W | Bank address |
| addr_ap | input | 1 | Address bit for auto-precharge / all-bank precharge |
| cmd_code | output | 4 | Registered decoded command |
| illegal_cmd | output | 1 | One-cycle flag for a rule violation |
| bank_state | output | 2*NUM_BANKS | Packed per-bank state |

## Verification
The embedded properties check several rules on every cycle. A precharging bank may only leave toward idle. A bank may enter reading only from an open row. The precharge timer stays within its bound. No flag is raised while clock enable was low, and no flag is raised on a deselect or a no-op. An accepted refresh or mode set requires all banks to have been idle. The bench scenarios are needed for everything that depends on counted windows: the exact cycle when a burst ends, the restart on a second read, the first legal activate after precharge, burst stop against a closed window, cross-bank burst termination, and the no-effect behaviour of clock-enable-low cycles, which is observed through `bank_state`.

// File: rtl/sdram_mon_pkg.sv
`timescale 1ns/1ps
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    CMD_DESL  = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_BST   = 4'd2,
    CMD_READ  = 4'd3,
    CMD_WRITE = 4'd4,
    CMD_ACT   = 4'd5,
    CMD_PRE   = 4'd6,
    CMD_REF   = 4'd7,
    CMD_MRS   = 4'd8
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE   = 2'd0,
    BK_OPEN   = 2'd1,
    BK_READ   = 2'd2,
    BK_PRECH  = 2'd3
  } bank_st_e;

  // Pin pattern to command; chip select high masks the strobes.
  function automatic cmd_e decode_pins(input logic cs_n, input logic ras_n,
                                       input logic cas_n, input logic we_n);
    if (cs_n) return CMD_DESL;
    case ({ras_n, cas_n, we_n})
      3'b111:  return CMD_NOP;
      3'b110:  return CMD_BST;
      3'b101:  return CMD_READ;
      3'b100:  return CMD_WRITE;
      3'b011:  return CMD_ACT;
      3'b010:  return CMD_PRE;
      3'b001:  return CMD_REF;
      default: return CMD_MRS;
    endcase
  endfunction

  // Rule for a command aimed at one bank, given that bank's state.
  function automatic logic bank_rule_ok(input bank_st_e st, input cmd_e c);
    case (c)
      CMD_READ, CMD_WRITE: return (st == BK_OPEN) || (st == BK_READ);
      CMD_ACT:             return st == BK_IDLE;
      default:             return 1'b1;
    endcase
  endfunction

  // Timer reload: a window of span cycles seen by commands means span-2.
  function automatic int window_load(input int span);
    return (span >= 2) ? span - 2 : 0;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
`timescale 1ns/1ps
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd,
  output logic is_banked,
  output logic is_global
);
  assign cmd       = decode_pins(cs_n, ras_n, cas_n, we_n);
  assign is_banked = (cmd == CMD_READ) || (cmd == CMD_WRITE) || (cmd == CMD_ACT);
  assign is_global = (cmd == CMD_REF) || (cmd == CMD_MRS) || (cmd == CMD_BST);
endmodule

// File: rtl/sdram_bank_tracker.sv
`timescale 1ns/1ps
module sdram_bank_tracker
  import sdram_mon_pkg::*;
#(
  parameter int RP_LOAD = 1,
  parameter int RD_LOAD = 4,
  parameter int CNT_W   = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     accept,
  input  cmd_e     cmd,
  input  logic     hit,
  input  logic     pre_all,
  output bank_st_e state
);
  logic [CNT_W-1:0] cnt, cnt_nx;
  bank_st_e         st_nx;
  logic             timer_done;
  logic             pre_here;

  assign timer_done = (cnt == '0);
  assign pre_here   = hit || pre_all;

  always_comb begin
    st_nx  = state;
    cnt_nx = cnt;
    // timers run every cycle, independent of clock enable
    if (state == BK_PRECH || state == BK_READ) begin
      if (timer_done) st_nx = (state == BK_PRECH) ? BK_IDLE : BK_OPEN;
      else            cnt_nx = cnt - 1'b1;
    end
    if (accept) begin
      case (cmd)
        CMD_ACT:   if (hit) st_nx = BK_OPEN;
        CMD_READ:  if (hit) begin
                     st_nx  = BK_READ;
                     cnt_nx = CNT_W'(RD_LOAD);
                   end else if (state == BK_READ) st_nx = BK_OPEN;
        CMD_WRITE: if (hit || state == BK_READ) st_nx = BK_OPEN;
        CMD_BST:   if (state == BK_READ) st_nx = BK_OPEN;
        CMD_PRE:   if (pre_here && (state == BK_OPEN || state == BK_READ)) begin
                     st_nx  = BK_PRECH;
                     cnt_nx = CNT_W'(RP_LOAD);
                   end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= BK_IDLE;
      cnt   <= '0;
    end else begin
      state <= st_nx;
      cnt   <= cnt_nx;
    end
  end

  AST_PRECH_EXITS_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == BK_PRECH && state != BK_PRECH) |-> state == BK_IDLE); // R8
  AST_READ_NEEDS_OPEN_ROW: assert property (@(posedge clk) disable iff (rst)
    (state == BK_READ && $past(state) != BK_READ) |-> $past(state) == BK_OPEN); // R4
  AST_PRECH_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
    state == BK_PRECH |-> cnt <= CNT_W'(RP_LOAD)); // R8
endmodule

// File: rtl/sdram_cmd_monitor.sv
`timescale 1ns/1ps
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RP      = 3,
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 2,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cke,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic [BANK_W-1:0]      ba,
  input  logic                   addr_ap,
  output logic [3:0]             cmd_code,
  output logic                   illegal_cmd,
  output logic [2*NUM_BANKS-1:0] bank_state
);
  localparam int RP_LOAD  = window_load(T_RP);
  localparam int RD_LOAD  = window_load(CAS_LAT + BURST_LEN);
  localparam int MAX_LOAD = (RP_LOAD > RD_LOAD) ? RP_LOAD : RD_LOAD;
  localparam int CNT_W    = $clog2(MAX_LOAD + 2);

  cmd_e                 cmd_now;
  logic                 cmd_banked, cmd_global;
  bank_st_e             st [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_idle, bank_reading;
  logic                 all_idle, any_reading;
  bank_st_e             target_st;
  logic                 cmd_legal, accept, violation;

  sdram_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cmd(cmd_now), .is_banked(cmd_banked), .is_global(cmd_global)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdram_bank_tracker #(.RP_LOAD(RP_LOAD), .RD_LOAD(RD_LOAD), .CNT_W(CNT_W)) u_trk (
      .clk(clk), .rst(rst), .accept(accept), .cmd(cmd_now),
      .hit(ba == BANK_W'(b)), .pre_all(addr_ap), .state(st[b])
    );
    assign bank_state[2*b +: 2] = st[b];
    assign bank_idle[b]         = (st[b] == BK_IDLE);
    assign bank_reading[b]      = (st[b] == BK_READ);
  end

  assign all_idle    = &bank_idle;
  assign any_reading = |bank_reading;
  assign target_st   = st[ba];

  always_comb begin
    if (cmd_banked)               cmd_legal = bank_rule_ok(target_st, cmd_now);
    else if (cmd_global)          cmd_legal = (cmd_now == CMD_BST) ? any_reading : all_idle;
    else                          cmd_legal = 1'b1;   // deselect, no-op, precharge
  end

  assign accept    = cke && cmd_legal;
  assign violation = cke && !cmd_legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_code    <= CMD_DESL;
      illegal_cmd <= 1'b0;
    end else begin
      cmd_code    <= cmd_now;
      illegal_cmd <= violation;
    end
  end

  AST_FLAG_NEEDS_CKE: assert property (@(posedge clk) disable iff (rst)
    illegal_cmd |-> $past(cke)); // R12
  AST_NOP_NEVER_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (cmd_code == CMD_DESL || cmd_code == CMD_NOP) |-> !illegal_cmd); // R1
  AST_GLOBAL_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    ((cmd_code == CMD_REF || cmd_code == CMD_MRS) && !illegal_cmd && $past(cke))
      |-> $past(all_idle)); // R9
endmodule

// File: tb/sdram_cmd_monitor_test.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_test;
  localparam int NB = 4;
  // command codes and state encodings as stated in the requirements
  localparam int C_DESL = 0, C_NOP = 1, C_BST = 2, C_RD = 3, C_WR = 4,
                 C_ACT = 5, C_PRE = 6, C_REF = 7, C_MRS = 8;
  localparam int S_IDLE = 0, S_OPEN = 1, S_READ = 2, S_PRE = 3;

  logic clk = 1'b0, rst = 1'b1, cke = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic addr_ap = 1'b0;
  logic [3:0] cmd_code;
  logic illegal_cmd;
  logic [2*NB-1:0] bank_state;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  int    q_cmd[$];
  bit    q_ill[$];
  string q_tag[$];

  always #4 clk = ~clk;

  sdram_cmd_monitor #(.NUM_BANKS(NB), .T_RP(3), .BURST_LEN(4), .CAS_LAT(2)) uut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr_ap(addr_ap), .cmd_code(cmd_code),
    .illegal_cmd(illegal_cmd), .bank_state(bank_state)
  );

  task automatic set_pins(input int code);
    case (code)
      C_DESL:  {cs_n, ras_n, cas_n, we_n} = 4'b1000;  // strobes say mode set, masked
      C_NOP:   {cs_n, ras_n, cas_n, we_n} = 4'b0111;
      C_BST:   {cs_n, ras_n, cas_n, we_n} = 4'b0110;
      C_RD:    {cs_n, ras_n, cas_n, we_n} = 4'b0101;
      C_WR:    {cs_n, ras_n, cas_n, we_n} = 4'b0100;
      C_ACT:   {cs_n, ras_n, cas_n, we_n} = 4'b0011;
      C_PRE:   {cs_n, ras_n, cas_n, we_n} = 4'b0010;
      C_REF:   {cs_n, ras_n, cas_n, we_n} = 4'b0001;
      default: {cs_n, ras_n, cas_n, we_n} = 4'b0000;
    endcase
  endtask

  // driver: called at a falling edge, drives one command for one cycle
  task automatic issue(input int code, input int bank, input bit ap,
                       input bit exp_ill, input string tag, input bit ke = 1'b1);
    set_pins(code);
    ba      = bank[1:0];
    addr_ap = ap;
    cke     = ke;
    q_cmd.push_back(code);
    q_ill.push_back(exp_ill);
    q_tag.push_back(tag);
    @(negedge clk);
    cke = 1'b1;
    set_pins(C_NOP);
  endtask

  task automatic nops(input int n, input string tag);
    for (int i = 0; i < n; i++) issue(C_NOP, 0, 1'b0, 1'b0, tag);
  endtask

  task automatic check_state(input int b, input int exp, input string tag);
    int act;
    act = int'(bank_state[2*b +: 2]);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s bank%0d state=%0d expected %0d", tag, b, act, exp);
    end
  endtask

  // monitor: compares registered outputs just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_cmd.size() > 0) begin
        int ec; bit ei; string et;
        ec = q_cmd.pop_front(); ei = q_ill.pop_front(); et = q_tag.pop_front();
        checks++;
        if (int'(cmd_code) !== ec || illegal_cmd !== ei) begin
          failures++;
          $display("FAIL %s cmd_code=%0d expected %0d illegal=%0b expected %0b",
                   et, cmd_code, ec, illegal_cmd, ei);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    set_pins(C_NOP);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R2 reset state
    checks++;
    if (cmd_code !== 4'd0 || illegal_cmd !== 1'b0 || bank_state !== '0) begin
      failures++;
      $display("FAIL R2 reset cmd=%0d ill=%0b st=%h expected 0 0 0", cmd_code, illegal_cmd, bank_state);
    end
    // R9 global commands with all idle
    issue(C_REF, 0, 0, 0, "R9 refresh idle");
    issue(C_MRS, 0, 0, 0, "R9 mode set idle");
    // R4 / R11 read to idle bank
    issue(C_RD, 0, 0, 1, "R4 read idle");
    check_state(0, S_IDLE, "R11 no effect");
    issue(C_BST, 0, 0, 1, "R6 burst stop none reading");
    // R3 activate
    issue(C_ACT, 0, 0, 0, "R3 act idle");
    check_state(0, S_OPEN, "R3 opened");
    issue(C_ACT, 0, 0, 1, "R3 act same bank");
    check_state(0, S_OPEN, "R11 stays open");
    issue(C_ACT, 1, 0, 0, "R3 act other bank");
    check_state(1, S_OPEN, "R3 bank1 opened");
    issue(C_REF, 0, 0, 1, "R9 refresh with open rows");
    issue(C_MRS, 0, 0, 1, "R9 mode set with open rows");
    issue(C_WR, 0, 0, 0, "R4 write open");
    check_state(0, S_OPEN, "R4 write keeps open");
    // R5 burst window
    issue(C_RD, 1, 0, 0, "R5 read");
    check_state(1, S_READ, "R4 reading");
    nops(4, "R5 nop");
    check_state(1, S_READ, "R5 still reading");
    nops(1, "R5 nop");
    check_state(1, S_OPEN, "R5 burst done");
    issue(C_BST, 0, 0, 1, "R6 burst stop after end");
    // R6 burst stop during read
    issue(C_RD, 1, 0, 0, "R6 read");
    issue(C_BST, 0, 0, 0, "R6 burst stop");
    check_state(1, S_OPEN, "R6 stopped");
    // R5 restart by second read
    issue(C_RD, 1, 0, 0, "R5 read a");
    nops(3, "R5 nop");
    issue(C_RD, 1, 0, 0, "R5 read b");
    nops(4, "R5 nop");
    check_state(1, S_READ, "R5 restarted");
    nops(1, "R5 nop");
    check_state(1, S_OPEN, "R5 restarted end");
    // R10 cross-bank termination, write cut
    issue(C_RD, 1, 0, 0, "R10 read b1");
    issue(C_RD, 0, 0, 0, "R10 read b0");
    check_state(1, S_OPEN, "R10 b1 ended");
    check_state(0, S_READ, "R10 b0 reading");
    issue(C_WR, 0, 0, 0, "R4 write cuts read");
    check_state(0, S_OPEN, "R4 write cut");
    // R7 / R8 precharge timing
    issue(C_RD, 0, 0, 0, "R7 read");
    issue(C_PRE, 0, 0, 0, "R7 precharge reading bank");
    check_state(0, S_PRE, "R7 precharging");
    check_state(1, S_OPEN, "R7 single bank only");
    issue(C_ACT, 0, 0, 1, "R8 act too early");
    check_state(0, S_PRE, "R11 still precharging");
    nops(1, "R8 nop");
    check_state(0, S_IDLE, "R8 idle");
    issue(C_ACT, 0, 0, 0, "R8 act at tRP");
    issue(C_PRE, 2, 0, 0, "R7 precharge idle bank");
    check_state(2, S_IDLE, "R7 idle stays");
    // R12 clock enable low
    issue(C_RD, 2, 0, 0, "R12 read unchecked", 1'b0);
    issue(C_ACT, 2, 0, 0, "R12 act ignored", 1'b0);
    check_state(2, S_IDLE, "R12 no effect");
    // R7 all-bank precharge, R9 refresh gating
    issue(C_PRE, 3, 1, 0, "R7 precharge all");
    check_state(0, S_PRE, "R7 all b0");
    check_state(1, S_PRE, "R7 all b1");
    check_state(3, S_IDLE, "R7 all b3");
    issue(C_REF, 0, 0, 1, "R9 refresh while precharging");
    nops(1, "R9 nop");
    issue(C_REF, 0, 0, 0, "R9 refresh after tRP");
    // R1 deselect masks strobes
    issue(C_DESL, 0, 0, 0, "R1 deselect");
    nops(2, "R1 nop");
    finish_run();
  end
endmodule